// File: doc/BRIEF.md
# Fixed-Point Hyperbolic Tangent Mapper

This block turns a signed 16-bit code `u` into `a = tanh(u)` as a signed Q1.15 code. The input covers the bounded range ±Umax, where Umax = atanh(1 − 1e-6) ≈ 7.2543. The code holds round(u × S), with S = 32767 / Umax ≈ 4516.9.

The unit works on |u| and puts the sign back at the end. The upper six bits of |u| choose one of 64 equal segments. For each segment a cubic polynomial, expanded about the segment midpoint, is taken from a constant table. The table is computed at elaboration time. The polynomial is evaluated in Horner form on the signed offset from the midpoint. Every place where precision is dropped rounds half-to-even, and the fixed parameter `ROUND_MODE` names that rule.

The pipeline is three registers deep: table fetch, two multiply-adds, then the last multiply-add with output rounding, clamp and sign. A new input can be accepted on every clock. A valid flag travels beside the data.

Top module: `tanh_map_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly three rising edges earlier. Inputs offered on consecutive cycles all produce results, in the order they were offered, with no gaps.
- R2: While `rst_n` is low, and until the first accepted input has emerged, `out_valid` is 0.
- R3: Read `out_a` as code/32768. It is within 3 LSB of tanh(`in_u`/S) clamped to ±32767/32768, with S = 32767/atanh(1 − 1e-6). For |u| ≤ 1 this keeps the absolute error under 1e-4.
- R4: An input code of 0 produces an output code of exactly 0.
- R5: Odd symmetry is exact: the result for −x is the two's-complement negation of the result for x.
- R6: The output code is never 0x8000, so |a| never exceeds 32767/32768. Inputs +32767 and −32767 produce +32767 and −32767.
- R7: A positive input never gives a negative output, and a negative input never gives a positive output.
- R8: The out-of-domain code −32768 is treated as −32767 and produces −32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Qualifies `in_u` on this cycle |
| in_u | input | 16 | Signed input code, round(u × S) |
| out_valid | output | 1 | Qualifies `out_a` |
| out_a | output | 16 | Signed Q1.15 result tanh(u) |

## Verification
The hardest cases to reach from the ports are the seams of the segment table: codes whose low nine bits are all zeros or all ones. At those codes the Horner offset sits at its extreme of −1 or just under +1, and any loss of precision in the cubic term shows up. A sweep with a stride that is coprime to 512 walks the offset through many positions in many segments. Explicit probes hit both sides of several seams and the top segment, where the result must saturate. Symmetric pairs sent back to back, and bursts broken up by idle gaps, check exact negation and latency under a mixed valid pattern.

// File: rtl/tanh_map_pkg.sv
`timescale 1ns/1ps
package tanh_map_pkg;

    // Word and table geometry
    localparam int U_W      = 16;
    localparam int MAG_W    = U_W - 1;
    localparam int SEG_BITS = 6;
    localparam int N_SEG    = 1 << SEG_BITS;
    localparam int OFF_BITS = MAG_W - SEG_BITS;   // also the signed offset width
    localparam int OFF_FRAC = OFF_BITS - 1;
    localparam int COEF_W   = 20;
    localparam int ACC_W    = 24;
    localparam int PIPE_DEPTH = 3;

    // Binary-point positions of the coefficients, highest order first
    localparam int FR3 = 32;
    localparam int FR2 = 27;
    localparam int FR1 = 22;
    localparam int FR0 = 18;
    localparam int OUT_FRAC = U_W - 1;

    // Right shifts applied after each multiply
    localparam int SH_A   = FR3 + OFF_FRAC - FR2;
    localparam int SH_B   = FR2 + OFF_FRAC - FR1;
    localparam int SH_C   = FR1 + OFF_FRAC - FR0;
    localparam int SH_OUT = FR0 - OUT_FRAC;

    typedef enum logic [0:0] {RND_HALF_EVEN = 1'b0} round_mode_e;

    typedef struct packed {
        logic [COEF_W-1:0] k3;
        logic [COEF_W-1:0] k2;
        logic [COEF_W-1:0] k1;
        logic [COEF_W-1:0] k0;
    } coef_set_t;

    // Table generation arithmetic uses Q30 in 64-bit integers.
    // w is half a segment width in u units (256 / S); the other two are tanh(w) and tanh(2w).
    localparam int     GEN_FRAC  = 30;
    localparam longint GEN_ONE   = 64'sd1 <<< GEN_FRAC;
    localparam longint W_Q       = 64'sd60855574;
    localparam longint TANH_W_Q  = 64'sd60790494;
    localparam longint TANH_2W_Q = 64'sd121192542;

    function automatic longint qmul(longint a, longint b);
        return (a * b + (64'sd1 <<< (GEN_FRAC - 1))) >>> GEN_FRAC;
    endfunction

    function automatic longint gen_rescale(longint v, int sh);
        if (sh > 0)
            return (v + (64'sd1 <<< (sh - 1))) >>> sh;
        else
            return v <<< (-sh);
    endfunction

    // Cubic Taylor coefficients about the midpoint of segment k, scaled so that
    // the polynomial variable is the offset normalised to [-1, 1).
    function automatic coef_set_t seg_coef(int k);
        longint t, tt, s, w2, w3, c0, c1, c2, c3;
        coef_set_t r;
        t = TANH_W_Q;
        for (int i = 0; i < k; i++)
            t = ((t + TANH_2W_Q) <<< GEN_FRAC) / (GEN_ONE + qmul(t, TANH_2W_Q));
        tt = qmul(t, t);
        s  = GEN_ONE - tt;
        w2 = qmul(W_Q, W_Q);
        w3 = qmul(w2, W_Q);
        c0 = t;
        c1 = qmul(s, W_Q);
        c2 = -qmul(qmul(t, s), w2);
        c3 = qmul(qmul(s, 3 * tt - GEN_ONE), w3) / 3;
        r.k0 = COEF_W'(gen_rescale(c0, GEN_FRAC - FR0));
        r.k1 = COEF_W'(gen_rescale(c1, GEN_FRAC - FR1));
        r.k2 = COEF_W'(gen_rescale(c2, GEN_FRAC - FR2));
        r.k3 = COEF_W'(gen_rescale(c3, GEN_FRAC - FR3));
        return r;
    endfunction

endpackage

// File: rtl/tanh_coef_rom.sv
`timescale 1ns/1ps
module tanh_coef_rom
    import tanh_map_pkg::*;
(
    input  logic [SEG_BITS-1:0] seg_idx,
    output coef_set_t           coef
);

    coef_set_t rom [N_SEG];

    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
        localparam coef_set_t ENTRY = seg_coef(k);
        assign rom[k] = ENTRY;
    end

    assign coef = rom[seg_idx];

endmodule

// File: rtl/tanh_horner_mac.sv
`timescale 1ns/1ps
module tanh_horner_mac #(
    parameter int A_W   = 24,
    parameter int Q_W   = 9,
    parameter int C_W   = 20,
    parameter int SHIFT = 13,
    parameter int O_W   = 24
) (
    input  logic signed [A_W-1:0] acc_in,
    input  logic signed [Q_W-1:0] q,
    input  logic signed [C_W-1:0] coef,
    output logic signed [O_W-1:0] acc_out
);

    localparam int P_W = A_W + Q_W;

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] kept;
    logic signed [P_W-1:0] rounded;
    logic                  tie_up;

    assign prod    = P_W'(acc_in) * P_W'(q);
    assign kept    = prod >>> SHIFT;
    // Half-to-even: round up above half, or at exactly half when the kept LSB is odd
    assign tie_up  = prod[SHIFT-1] & ((|prod[SHIFT-2:0]) | kept[0]);
    assign rounded = kept + P_W'(tie_up);
    assign acc_out = O_W'(rounded + P_W'(coef));

endmodule

// File: rtl/tanh_valid_pipe.sv
`timescale 1ns/1ps
module tanh_valid_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic v_in,
    output logic v_out
);

    logic [DEPTH-1:0] stages;

    if (DEPTH == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stages <= '0;
            else        stages <= v_in;
        end
    end else begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stages <= '0;
            else        stages <= {stages[DEPTH-2:0], v_in};
        end
    end

    assign v_out = stages[DEPTH-1];

endmodule

// File: rtl/tanh_map_unit.sv
`timescale 1ns/1ps
module tanh_map_unit
    import tanh_map_pkg::*;
#(
    parameter round_mode_e ROUND_MODE = RND_HALF_EVEN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [U_W-1:0] in_u,
    output logic                  out_valid,
    output logic signed [U_W-1:0] out_a
);

    localparam logic signed [U_W-1:0]   CODE_MIN = {1'b1, {(U_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] MAG_CAP  = ACC_W'((1 <<< MAG_W) - 1);

    if (ROUND_MODE != RND_HALF_EVEN) begin : g_mode_guard
        $error("tanh_map_unit supports only half-to-even rounding");
    end

    // ---------------- stage 1: fold sign, split index/offset, fetch row
    logic [MAG_W-1:0]           mag;
    logic [SEG_BITS-1:0]        seg_idx;
    logic [OFF_BITS-1:0]        off;
    logic signed [OFF_BITS-1:0] q_now;
    coef_set_t                  row;

    always_comb begin
        if (!in_u[U_W-1])       mag = in_u[MAG_W-1:0];
        else if (in_u == CODE_MIN) mag = '1;
        else                    mag = MAG_W'(-in_u);
    end

    assign seg_idx = mag[MAG_W-1 -: SEG_BITS];
    assign off     = mag[OFF_BITS-1:0];
    // offset from the segment midpoint, as a signed value with OFF_FRAC fraction bits
    assign q_now   = {~off[OFF_BITS-1], off[OFF_BITS-2:0]};

    tanh_coef_rom u_rom (
        .seg_idx (seg_idx),
        .coef    (row)
    );

    logic                       s1_neg;
    logic signed [OFF_BITS-1:0] s1_q;
    coef_set_t                  s1_row;

    always_ff @(posedge clk) begin
        s1_neg <= in_u[U_W-1];
        s1_q   <= q_now;
        s1_row <= row;
    end

    // ---------------- stage 2: two Horner steps
    logic signed [ACC_W-1:0] acc2;
    logic signed [ACC_W-1:0] acc1;

    tanh_horner_mac #(
        .A_W(ACC_W), .Q_W(OFF_BITS), .C_W(COEF_W), .SHIFT(SH_A), .O_W(ACC_W)
    ) u_mac_a (
        .acc_in  (ACC_W'($signed(s1_row.k3))),
        .q       (s1_q),
        .coef    ($signed(s1_row.k2)),
        .acc_out (acc2)
    );

    tanh_horner_mac #(
        .A_W(ACC_W), .Q_W(OFF_BITS), .C_W(COEF_W), .SHIFT(SH_B), .O_W(ACC_W)
    ) u_mac_b (
        .acc_in  (acc2),
        .q       (s1_q),
        .coef    ($signed(s1_row.k1)),
        .acc_out (acc1)
    );

    logic                       s2_neg;
    logic signed [OFF_BITS-1:0] s2_q;
    logic [COEF_W-1:0]          s2_k0;
    logic signed [ACC_W-1:0]    s2_acc1;

    always_ff @(posedge clk) begin
        s2_neg  <= s1_neg;
        s2_q    <= s1_q;
        s2_k0   <= s1_row.k0;
        s2_acc1 <= acc1;
    end

    // ---------------- stage 3: last step, output rounding, clamp, sign
    logic signed [ACC_W-1:0] acc0;
    logic signed [ACC_W-1:0] acc0_kept;
    logic signed [ACC_W-1:0] mag_rnd;
    logic                    out_up;
    logic [MAG_W-1:0]        mag_sat;
    logic signed [U_W-1:0]   mag_ext;

    tanh_horner_mac #(
        .A_W(ACC_W), .Q_W(OFF_BITS), .C_W(COEF_W), .SHIFT(SH_C), .O_W(ACC_W)
    ) u_mac_c (
        .acc_in  (s2_acc1),
        .q       (s2_q),
        .coef    ($signed(s2_k0)),
        .acc_out (acc0)
    );

    assign acc0_kept = acc0 >>> SH_OUT;
    assign out_up    = acc0[SH_OUT-1] & ((|acc0[SH_OUT-2:0]) | acc0_kept[0]);
    assign mag_rnd   = acc0_kept + ACC_W'(out_up);

    always_comb begin
        if (mag_rnd < 0)            mag_sat = '0;
        else if (mag_rnd > MAG_CAP) mag_sat = '1;
        else                        mag_sat = MAG_W'(mag_rnd);
    end

    assign mag_ext = {1'b0, mag_sat};

    always_ff @(posedge clk) begin
        out_a <= s2_neg ? -mag_ext : mag_ext;
    end

    tanh_valid_pipe #(.DEPTH(PIPE_DEPTH)) u_vpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (in_valid),
        .v_out (out_valid)
    );

endmodule

// File: rtl/tanh_map_checker.sv
`timescale 1ns/1ps
module tanh_map_checker
    import tanh_map_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic signed [U_W-1:0] in_u,
    input logic                  out_valid,
    input logic signed [U_W-1:0] out_a
);

    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd3) |-> !out_valid);

    a_r4_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && $past(in_u, 3) == '0) |-> (out_a == '0));

    a_r6_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_a != {1'b1, {(U_W-1){1'b0}}}));

    a_r7_sign_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && $signed($past(in_u, 3)) > 0) |-> !out_a[U_W-1]);

    a_r7_sign_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && $signed($past(in_u, 3)) < 0) |-> (out_a <= 0));

endmodule

bind tanh_map_unit tanh_map_checker u_chk (.*);

// File: tb/tb_tanh_map_unit.sv
`timescale 1ns/1ps
module tb_tanh_map_unit;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic signed [15:0] in_u;
    logic               out_valid;
    logic signed [15:0] out_a;

    always #2.5 clk = ~clk;   // 200 MHz

    tanh_map_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_u      (in_u),
        .out_valid (out_valid),
        .out_a     (out_a)
    );

    typedef struct {
        int     id;
        int     x;
        longint stamp;
    } item_t;

    item_t  sb [$];
    int     res [int];
    int     pair_p [$];
    int     pair_n [$];
    int     n_vec = 0;
    int     n_bad = 0;
    int     next_id = 0;
    longint cyc = 0;
    real    scale_s;
    bit     finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(int x, output int id);
        item_t it;
        @(negedge clk);
        in_valid <= 1'b1;
        in_u     <= x[15:0];
        id       = next_id;
        next_id++;
        it.id = id; it.x = x; it.stamp = cyc;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid <= 1'b0;
            in_u     <= 16'sh5A5A;
        end
    endtask

    task automatic drive_pair(int x);
        int a, b;
        drive(x, a);
        drive(-x, b);
        pair_p.push_back(a);
        pair_n.push_back(b);
    endtask

    function automatic real model(int x);
        real e;
        int  xc;
        xc = (x < -32767) ? -32767 : x;          // R8 domain fold
        e  = $tanh(real'(xc) / scale_s) * 32768.0;
        if (e > 32767.0)  e = 32767.0;
        if (e < -32767.0) e = -32767.0;
        return e;
    endfunction

    // Monitor: pops the scoreboard whenever a result appears
    item_t mon_it;
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "result with nothing pending", 1, 0);
            end else begin
                real e, d;
                mon_it = sb.pop_front();
                check(cyc == mon_it.stamp + 3, "R1", "result cycle", cyc, mon_it.stamp + 3);
                e = model(mon_it.x);
                d = real'(int'(out_a)) - e;
                if (d < 0.0) d = -d;
                check(d <= 3.0, "R3", $sformatf("accuracy x=%0d", mon_it.x),
                      int'(out_a), longint'($rtoi(e)));
                check(out_a != 16'sh8000, "R6", "code 0x8000 emitted", int'(out_a), -32767);
                res[mon_it.id] = int'(out_a);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int id_zero, id_pmax, id_nmax, id_min, tmp;
        scale_s  = 32767.0 / (0.5 * $ln((2.0 - 1.0e-6) / 1.0e-6));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_u     = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R2", "valid during reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R2", "valid after reset", out_valid, 0);

        // Exact points
        drive(0, id_zero);
        drive(32767, id_pmax);
        drive(-32767, id_nmax);
        drive(-32768, id_min);

        // Segment seams and near-zero probes, in symmetric pairs (R5)
        drive_pair(1);
        drive_pair(255);
        drive_pair(256);
        drive_pair(511);
        drive_pair(512);
        drive_pair(513);
        drive_pair(4516);
        drive_pair(16383);
        drive_pair(16384);
        drive_pair(32256);
        drive_pair(32766);

        // Back-to-back sweep, stride coprime to the segment size
        for (int x = -32767; x <= 32767; x += 61) drive(x, tmp);

        // Bursts broken by gaps
        for (int i = 0; i < 40; i++) begin
            drive_pair(i * 797 + 3);
            idle(i % 3);
        end
        idle(8);
        wait (sb.size() == 0);
        idle(2);

        check(res[id_zero] == 0, "R4", "zero input", res[id_zero], 0);
        check(res[id_pmax] == 32767, "R6", "top code", res[id_pmax], 32767);
        check(res[id_nmax] == -32767, "R6", "bottom code", res[id_nmax], -32767);
        check(res[id_min] == -32767, "R8", "out-of-domain code", res[id_min], -32767);
        for (int i = 0; i < pair_p.size(); i++) begin
            check(res[pair_n[i]] == -res[pair_p[i]], "R5", "negation pair",
                  res[pair_n[i]], -res[pair_p[i]]);
            check(res[pair_p[i]] >= 0, "R7", "sign of positive input", res[pair_p[i]], 0);
        end
        check(out_valid == 1'b0, "R1", "valid with no input", out_valid, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule